// File: doc/BRIEF.md
# Dual-Address Triggered DMA Channel

This block is one DMA channel that copies data units from a programmable source address to a programmable destination address. Each unit moves in two bus phases. A read phase loads the source data into an internal holding register. A write phase then stores that register to the destination. The channel runs in single-transfer mode: each trigger pulse, taken while the channel is enabled and idle, moves exactly one unit. Moving N units therefore takes N triggers.

Software programs the channel through a plain write port:
- a 24-bit down-counting transfer counter, written in three byte fields;
- two 28-bit addresses, each written as a low 16-bit part and a high 12-bit part;
- a control word that sets the enable, the unit size and the stepping mode of each address.

When the counter steps from one to zero, the channel clears its own enable and pulses `done`. A counter loaded with zero wraps to all ones on its first unit, so a zero load gives the largest possible count.

The bus master port uses a valid/ready request. The design raises `bus_valid` and holds `bus_write`, `bus_addr`, `bus_lane` and `bus_wdata` unchanged until it sees `bus_ready` high at a clock edge. That edge completes the phase. A read phase takes `bus_rdata` in the same cycle as its handshake, so the slave must drive read data whenever it raises ready during a read. The slave may hold ready low for as long as it likes, and the phase simply waits.

Top module: `dma_dual_chan`

## Requirements
- R1: After reset, `chan_en` is 0, `remaining` is 0, `done` is 0 and `bus_valid` is 0.
- R2: A trigger taken while the channel is enabled and idle starts a read phase on the next cycle (`bus_valid`=1, `bus_write`=0, `bus_addr`=source). After the read handshake, a write phase (`bus_write`=1, `bus_addr`=destination) carries the data that was read.
- R3: While `bus_valid` is high and `bus_ready` is low, the request stays valid and `bus_write`, `bus_addr`, `bus_lane` and `bus_wdata` hold their values.
- R4: One trigger moves exactly one unit. A trigger arriving while the channel is disabled or while a transfer is in progress starts nothing and is not queued.
- R5: Register writes at `cfg_addr` 0, 1 and 2 load `cfg_wdata[7:0]` into counter bits 7:0, 15:8 and 23:16. `remaining` shows the counter. The counter drops by one at each completed write phase.
- R6: A counter loaded with zero reads 0xFFFFFF after the first unit. The channel stays enabled and `done` does not pulse.
- R7: When a unit completes with the counter at 1, on the next cycle `remaining` is 0, `chan_en` is 0 and `done` is high for exactly one cycle.
- R8: The source address is loaded as low bits 15:0 at `cfg_addr` 3 (`cfg_wdata[15:0]`) and high bits 27:16 at `cfg_addr` 4 (`cfg_wdata[11:0]`). The destination address uses `cfg_addr` 5 and 6 in the same way.
- R9: The control word at `cfg_addr` 7 holds the source step mode in bits 3:2 and the destination step mode in bits 5:4. The codes are 0 fixed, 1 increment, 2 decrement, 3 fixed. Each address steps after every completed unit by 1 for byte units and by 2 for half-word units.
- R10: Control bit 1 selects the unit size (0 byte, 1 half-word). A half-word access uses `bus_lane`=11 and the full data word. A byte access uses `bus_lane`=01 when address bit 0 is 0 and 10 when it is 1. A byte read keeps the addressed byte. A byte write drives that byte on both halves of `bus_wdata`.
- R11: Control bit 0 is the channel enable. Any register write made while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register select |
| cfg_wdata | input | 16 | Register write data |
| trig | input | 1 | Transfer trigger, one unit per accepted pulse |
| bus_valid | output | 1 | Bus request valid |
| bus_write | output | 1 | 1 for write phase, 0 for read phase |
| bus_addr | output | 28 | Bus address |
| bus_lane | output | 2 | Byte-lane select (bit 0 low byte, bit 1 high byte) |
| bus_wdata | output | 16 | Write data |
| bus_ready | input | 1 | Bus slave accepts the phase this cycle |
| bus_rdata | input | 16 | Read data, valid with ready in a read phase |
| chan_en | output | 1 | Channel enable state |
| remaining | output | 24 | Current transfer counter |
| done | output | 1 | One-cycle pulse when the count runs out |

## Verification
The assertions check every cycle that a stalled request holds steady and that a read handshake is always followed by a write phase. They also check that the idle state ignores triggers while the channel is disabled, and that each completed unit lowers the counter by exactly one, wrapping from zero. They further check that fixed-mode addresses do not move, that register writes leave the control word alone during a transfer, that byte lanes match the unit size, and that `done` is a single cycle that coincides with a cleared enable. Only the bench scenarios can show the data values that land at each address and the field positions of the register map. They also show that stray triggers are dropped rather than queued, that a zero load runs as the maximum count, and that an address written during a stalled phase has no effect on later units.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } xfer_state_e;

  typedef enum logic [1:0] {
    AM_FIXED = 2'd0,
    AM_INC   = 2'd1,
    AM_DEC   = 2'd2,
    AM_HOLD  = 2'd3
  } addr_mode_e;

  // control word layout, bit 0 upward: en, half, src_mode, dst_mode
  typedef struct packed {
    addr_mode_e dst_mode;
    addr_mode_e src_mode;
    logic       half;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int BUS_W  = 16;

  localparam logic [3:0] REG_CNT0   = 4'd0;
  localparam logic [3:0] REG_SRC_LO = 4'd3;
  localparam logic [3:0] REG_SRC_HI = 4'd4;
  localparam logic [3:0] REG_DST_LO = 4'd5;
  localparam logic [3:0] REG_DST_HI = 4'd6;
  localparam logic [3:0] REG_CTRL   = 4'd7;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_chan_pkg::*;
#(
  parameter int NB = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [3:0]          cfg_addr,
  input  logic [BUS_W-1:0]    cfg_wdata,
  input  logic                busy,
  input  logic                clr_en,
  output ctrl_t               ctrl,
  output logic [NB-1:0]       cnt_ld,
  output logic [1:0][1:0]     addr_ld,
  output logic [BUS_W-1:0]    ld_data
);

  logic wr_ok;
  assign wr_ok   = cfg_we && !busy;
  assign ld_data = cfg_wdata;

  for (genvar i = 0; i < NB; i++) begin : g_cnt_dec
    assign cnt_ld[i] = wr_ok && (cfg_addr == REG_CNT0 + 4'(i));
  end

  assign addr_ld[0][0] = wr_ok && (cfg_addr == REG_SRC_LO);
  assign addr_ld[0][1] = wr_ok && (cfg_addr == REG_SRC_HI);
  assign addr_ld[1][0] = wr_ok && (cfg_addr == REG_DST_LO);
  assign addr_ld[1][1] = wr_ok && (cfg_addr == REG_DST_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (clr_en) begin
      ctrl.en <= 1'b0;
    end else if (wr_ok && cfg_addr == REG_CTRL) begin
      ctrl <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
    end
  end

  // R11: register writes made while a transfer runs leave the control word alone
  a_r11_ctrl_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !clr_en |=> $stable(ctrl));

endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter #(
  parameter int CW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW/8-1:0]  ld,
  input  logic [7:0]       ld_byte,
  input  logic             dec,
  output logic [CW-1:0]    count,
  output logic             last
);

  localparam int NB = CW / 8;

  logic [CW-1:0] next;

  always_comb begin
    next = count;
    if (dec) begin
      next = count - CW'(1);
    end else begin
      for (int i = 0; i < NB; i++) begin
        if (ld[i]) next[i*8 +: 8] = ld_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= next;
  end

  assign last = (count == CW'(1));

  // R5: each completed unit lowers the counter by exactly one
  a_r5_dec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> count == $past(count) - CW'(1));

  // R6: a zero counter wraps to all ones on a unit
  a_r6_zero_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    dec && count == '0 |=> count == {CW{1'b1}});

endmodule

// File: rtl/dma_addr_reg.sv
module dma_addr_reg
  import dma_chan_pkg::*;
#(
  parameter int AW = 28,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [LW-1:0] ld_data,
  input  logic          step,
  input  addr_mode_e    mode,
  input  logic          half,
  output logic [AW-1:0] addr
);

  localparam int HW = AW - LW;

  logic [AW-1:0] delta;
  logic [AW-1:0] stepped;

  assign delta = half ? AW'(2) : AW'(1);

  always_comb begin
    unique case (mode)
      AM_INC:  stepped = addr + delta;
      AM_DEC:  stepped = addr - delta;
      default: stepped = addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (step) begin
      addr <= stepped;
    end else begin
      if (ld_lo) addr[LW-1:0]  <= ld_data;
      if (ld_hi) addr[AW-1:LW] <= ld_data[HW-1:0];
    end
  end

  // R9: fixed-mode addresses do not move on a unit
  a_r9_fixed_stays: assert property (@(posedge clk) disable iff (!rst_n)
    step && (mode == AM_FIXED || mode == AM_HOLD) |=> $stable(addr));

  // R9: increment mode advances by the unit size
  a_r9_inc_by_size: assert property (@(posedge clk) disable iff (!rst_n)
    step && mode == AM_INC |=> addr == $past(addr) + (($past(half)) ? AW'(2) : AW'(1)));

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_chan_pkg::*;
#(
  parameter int AW = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             en,
  input  logic             half,
  input  logic             last,
  input  logic [AW-1:0]    src_addr,
  input  logic [AW-1:0]    dst_addr,
  input  logic             bus_ready,
  input  logic [BUS_W-1:0] bus_rdata,
  output logic             bus_valid,
  output logic             bus_write,
  output logic [AW-1:0]    bus_addr,
  output logic [1:0]       bus_lane,
  output logic [BUS_W-1:0] bus_wdata,
  output logic             busy,
  output logic             unit_done,
  output logic             done_q
);

  xfer_state_e     state;
  logic [BUS_W-1:0] hold;
  logic [BUS_W-1:0] rd_pick;

  assign bus_valid = (state != ST_IDLE);
  assign bus_write = (state == ST_WRITE);
  assign bus_addr  = bus_write ? dst_addr : src_addr;
  assign bus_lane  = half ? 2'b11 : (bus_addr[0] ? 2'b10 : 2'b01);
  assign bus_wdata = half ? hold : {hold[7:0], hold[7:0]};
  assign busy      = bus_valid;
  assign unit_done = (state == ST_WRITE) && bus_ready;

  always_comb begin
    if (half)             rd_pick = bus_rdata;
    else if (bus_addr[0]) rd_pick = {8'h00, bus_rdata[15:8]};
    else                  rd_pick = {8'h00, bus_rdata[7:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      hold   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= unit_done && last;
      unique case (state)
        ST_IDLE:  if (trig && en) state <= ST_READ;
        ST_READ:  if (bus_ready) begin
                    hold  <= rd_pick;
                    state <= ST_WRITE;
                  end
        ST_WRITE: if (bus_ready) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R3: a stalled phase keeps its request steady
  a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_write) && $stable(bus_addr)
                                && $stable(bus_lane) && $stable(bus_wdata));

  // R2: a completed read is followed by a write phase
  a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write && bus_ready |=> bus_valid && bus_write);

  // R2: a new request always opens with a read
  a_r2_opens_with_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |-> !bus_write);

  // R4: idle stays idle without an enabled trigger
  a_r4_idle_without_trig: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE && !(trig && en) |=> state == ST_IDLE);

  // R10: byte units touch exactly one lane
  a_r10_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !half |-> $countones(bus_lane) == 1);

endmodule

// File: rtl/dma_dual_chan.sv
module dma_dual_chan
  import dma_chan_pkg::*;
#(
  parameter int AW = 28,
  parameter int CW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_addr,
  input  logic [15:0]      cfg_wdata,
  input  logic             trig,
  output logic             bus_valid,
  output logic             bus_write,
  output logic [AW-1:0]    bus_addr,
  output logic [1:0]       bus_lane,
  output logic [15:0]      bus_wdata,
  input  logic             bus_ready,
  input  logic [15:0]      bus_rdata,
  output logic             chan_en,
  output logic [CW-1:0]    remaining,
  output logic             done
);

  localparam int NB = CW / 8;

  ctrl_t             ctrl;
  logic [NB-1:0]     cnt_ld;
  logic [1:0][1:0]   addr_ld;
  logic [BUS_W-1:0]  ld_data;
  logic              busy;
  logic              unit_done;
  logic              last;
  logic              clr_en;
  logic [AW-1:0]     addr_q [2];
  addr_mode_e        mode_sel [2];

  assign clr_en      = unit_done && last;
  assign mode_sel[0] = ctrl.src_mode;
  assign mode_sel[1] = ctrl.dst_mode;

  dma_cfg_regs #(.NB(NB)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .busy(busy), .clr_en(clr_en), .ctrl(ctrl),
    .cnt_ld(cnt_ld), .addr_ld(addr_ld), .ld_data(ld_data)
  );

  dma_xfer_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ld(cnt_ld), .ld_byte(ld_data[7:0]),
    .dec(unit_done), .count(remaining), .last(last)
  );

  for (genvar g = 0; g < 2; g++) begin : g_addr
    dma_addr_reg #(.AW(AW), .LW(BUS_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .ld_lo(addr_ld[g][0]), .ld_hi(addr_ld[g][1]),
      .ld_data(ld_data), .step(unit_done), .mode(mode_sel[g]),
      .half(ctrl.half), .addr(addr_q[g])
    );
  end

  dma_xfer_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .trig(trig), .en(ctrl.en), .half(ctrl.half),
    .last(last), .src_addr(addr_q[0]), .dst_addr(addr_q[1]),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_lane(bus_lane),
    .bus_wdata(bus_wdata), .busy(busy), .unit_done(unit_done), .done_q(done)
  );

  assign chan_en = ctrl.en;

  // R7: done coincides with a cleared enable and an empty counter
  a_r7_done_state: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !chan_en && remaining == '0);

  // R7: done lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/dma_dual_chan_test.sv
module dma_dual_chan_test;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        trig = 0;
  logic        bus_valid, bus_write, bus_ready, chan_en, done;
  logic [27:0] bus_addr;
  logic [1:0]  bus_lane;
  logic [15:0] bus_wdata, bus_rdata;
  logic [23:0] remaining;
  logic        rdy = 1;

  int checks = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [27:0] rd_addr, wr_addr;
  logic [1:0]  rd_lane, wr_lane;
  logic [15:0] wr_data;
  bit finished = 0;

  always #10 clk = ~clk;

  function automatic logic [15:0] mem_word(input logic [27:0] a);
    return {a[7:0] ^ 8'hA5, a[7:0] + 8'h3C};
  endfunction

  function automatic logic [7:0] mem_byte(input logic [27:0] a);
    logic [15:0] w;
    w = mem_word(a);
    return a[0] ? w[15:8] : w[7:0];
  endfunction

  assign bus_ready = rdy;
  assign bus_rdata = mem_word(bus_addr);

  dma_dual_chan uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .trig(trig), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_lane(bus_lane),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .chan_en(chan_en), .remaining(remaining), .done(done)
  );

  // record each handshake that the next rising edge will complete
  always @(negedge clk) begin
    #2;
    if (bus_valid && bus_ready) begin
      if (bus_write) begin
        wr_cnt++; wr_addr = bus_addr; wr_lane = bus_lane; wr_data = bus_wdata;
      end else begin
        rd_cnt++; rd_addr = bus_addr; rd_lane = bus_lane;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic setup(input logic [27:0] src, input logic [27:0] dst,
                       input logic [23:0] cnt, input logic [5:0] ctl);
    wr_reg(4'd0, {8'h0, cnt[7:0]});
    wr_reg(4'd1, {8'h0, cnt[15:8]});
    wr_reg(4'd2, {8'h0, cnt[23:16]});
    wr_reg(4'd3, src[15:0]);
    wr_reg(4'd4, {4'h0, src[27:16]});
    wr_reg(4'd5, dst[15:0]);
    wr_reg(4'd6, {4'h0, dst[27:16]});
    wr_reg(4'd7, {10'h0, ctl});
  endtask

  task automatic pulse_trig;
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
  endtask

  task automatic wait_unit;
    int start;
    start = wr_cnt;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #3;
      if (wr_cnt != start) break;
    end
    @(negedge clk); #1;
  endtask

  task automatic one_unit;
    pulse_trig();
    wait_unit();
  endtask

  task automatic t_reset;
    check("R1 chan_en", chan_en, 0);
    check("R1 remaining", remaining, 0);
    check("R1 done", done, 0);
    check("R1 bus_valid", bus_valid, 0);
  endtask

  task automatic t_counter_fields;
    wr_reg(4'd0, 16'hFF12);
    wr_reg(4'd1, 16'hAA34);
    wr_reg(4'd2, 16'h0056);
    #1 check("R5 byte fields", remaining, 24'h563412);
  endtask

  task automatic t_byte_inc;
    logic [27:0] s, d;
    s = 28'h3000A10; d = 28'h3000A80;
    setup(s, d, 24'd3, 6'b01_01_0_1);
    check("R11 enable bit", chan_en, 1);
    for (int u = 0; u < 3; u++) begin
      one_unit();
      check("R2 read addr", rd_addr, s + u);
      check("R8 R9 write addr", wr_addr, d + u);
      check("R10 read lane", rd_lane, (s[0] ^ u[0]) ? 2'b10 : 2'b01);
      check("R10 write lane", wr_lane, (d[0] ^ u[0]) ? 2'b10 : 2'b01);
      check("R2 R10 write data", wr_data, {2{mem_byte(s + u)}});
      check("R5 remaining", remaining, 2 - u);
      check("R7 done", done, u == 2);
    end
    check("R7 enable cleared", chan_en, 0);
    @(negedge clk); #1;
    check("R7 done one cycle", done, 0);
  endtask

  task automatic t_disabled_ignored;
    int r0;
    r0 = rd_cnt;
    pulse_trig();
    repeat (5) @(negedge clk);
    #3 check("R4 disabled trigger", rd_cnt, r0);
    check("R4 no request", bus_valid, 0);
  endtask

  task automatic t_half_stall;
    logic [27:0] s, d;
    int r0;
    s = 28'h3000A40; d = 28'h3000A90;
    setup(s, d, 24'd2, 6'b00_10_1_1);
    rdy = 0;
    r0 = rd_cnt;
    pulse_trig();
    for (int i = 0; i < 3; i++) begin
      #1 check("R3 stalled read", {bus_valid, bus_write, bus_addr}, {2'b10, s});
      if (i == 1) trig = 1;
      @(negedge clk);
      trig = 0;
    end
    rdy = 1;
    wait_unit();
    check("R4 one unit only", rd_cnt, r0 + 1);
    check("R10 half lane", wr_lane, 2'b11);
    check("R10 half data", wr_data, mem_word(s));
    check("R5 half remaining", remaining, 1);
    repeat (4) @(negedge clk);
    #3 check("R4 stray trigger dropped", rd_cnt, r0 + 1);
    one_unit();
    check("R9 src decrement by 2", rd_addr, s - 2);
    check("R9 dst fixed", wr_addr, d);
    check("R7 done half", done, 1);
  endtask

  task automatic t_zero_load;
    setup(28'h3000A20, 28'h3000A30, 24'd0, 6'b00_00_0_1);
    one_unit();
    check("R6 wrap", remaining, 24'hFFFFFF);
    check("R6 still enabled", chan_en, 1);
    check("R6 no done", done, 0);
    wr_reg(4'd7, 16'h0000);
    check("R11 disable write", chan_en, 0);
  endtask

  task automatic t_busy_writes;
    logic [27:0] s;
    s = 28'h3000A00;
    setup(s, 28'h3000AC0, 24'd5, 6'b01_01_0_1);
    rdy = 0;
    pulse_trig();
    wr_reg(4'd3, 16'h0B00);
    wr_reg(4'd7, 16'h0000);
    rdy = 1;
    wait_unit();
    check("R11 enable kept", chan_en, 1);
    check("R11 remaining", remaining, 4);
    one_unit();
    check("R11 source kept", rd_addr, s + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1;
    t_counter_fields();
    t_byte_inc();
    t_disabled_ignored();
    t_half_stall();
    t_zero_load();
    t_busy_writes();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule